// File: doc/BRIEF.md
# SWD Line Sequence Detector

This block listens passively to the clock and data wires of a two-wire serial debug link and picks out the two special line sequences that reset or select the link. The debug clock is not used as a clock: it is brought into the system clock domain through a synchronizer and treated as a sampled signal. A rising edge of the debug clock is found by comparing the synchronized level with its value one system cycle earlier.

On each rising edge, a counter tracks how many consecutive high data samples have been seen. When a low sample arrives after a long enough run of highs, the block reports a line reset with a one-cycle pulse and gives the length of the run. A 16-bit sliding window of rising-edge samples is compared against the link-switch pattern. A match is reported only while the companion transaction decoder says the link is waiting for a new request. That decoder uses either pulse to return to its request-wait state. The block never drives the link.

Top module: `swd_seq_detect`

## Requirements
- R1: While `rst_n` is low at a clock edge, `line_reset_pulse` and `switch_pulse` are 0 and `reset_len` is 0 after that edge.
- R2: A rising debug-clock edge that samples data low after at least 50 consecutive high samples produces a line reset. The line reset is a one-cycle `line_reset_pulse`, and `reset_len` then holds the length of the high run. The run counter then starts again from zero.
- R3: A low sample after fewer than 50 consecutive high samples produces no line reset.
- R4: The high-run counter saturates at 255, so any run of 255 or more high samples reports `reset_len` = 255.
- R5: Line reset detection works whatever the level of `idle_req`.
- R6: The link-switch pattern is the 16-bit value 0xE79E sent least significant bit first (bit order 0,1,1,1,1,0,0,1,1,1,1,0,0,1,1,1). It is matched on a sliding window of rising-edge samples, so any bits may come before it. A match at a rising edge where `idle_req` is high gives a one-cycle `switch_pulse`.
- R7: A completed switch pattern produces no `switch_pulse` when `idle_req` is low at its last rising edge.
- R8: A rising debug-clock edge seen while `clk_en` is low is ignored. It neither extends the high run nor ends it, and it produces no pulse.
- R9: Each pulse output is high for exactly one system clock cycle per detected sequence. It appears no more than four system cycles after the debug-clock rising edge at the input pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the debug clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_en | input | 1 | Qualifies sampling; rising edges are ignored while low |
| idle_req | input | 1 | High while the link waits for a new request; gates switch matching |
| swclk_in | input | 1 | Debug clock wire, asynchronous |
| swdio_in | input | 1 | Debug data wire, asynchronous |
| line_reset_pulse | output | 1 | One-cycle pulse on a detected line reset |
| switch_pulse | output | 1 | One-cycle pulse on a detected link-switch pattern |
| reset_len | output | 8 | High-run length captured at the last line reset, saturated |

## Verification
High runs of exactly 50 and 49 bits separate the threshold from an off-by-one. A run of 300 bits tells a saturating counter from one that wraps. The switch pattern is sent three ways: after a line reset, after unrelated leading bits, and with `idle_req` low. These show that the window slides and that the request-wait gate acts only on the switch match, not on the line reset. A long high run sent with `clk_en` low and then ended with sampling enabled shows that gated edges neither count toward nor end a run.

// File: rtl/swd_seq_pkg.sv
package swd_seq_pkg;
  localparam int unsigned DEF_CNT_W     = 8;
  localparam int unsigned DEF_RESET_MIN = 50;
  localparam int unsigned DEF_PAT_W     = 16;
  localparam logic [15:0] DEF_PATTERN   = 16'hE79E;
  localparam int unsigned DEF_SYNC      = 2;
endpackage

// File: rtl/swd_sync_edge.sv
module swd_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic swclk_in,
  input  logic swdio_in,
  output logic rise,
  output logic dio_s
);
  logic [STAGES-1:0] clk_chain;
  logic [STAGES-1:0] dio_chain;
  logic              clk_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_chain[0] <= 1'b0;
      dio_chain[0] <= 1'b0;
    end else begin
      clk_chain[0] <= swclk_in;
      dio_chain[0] <= swdio_in;
    end
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        clk_chain[g] <= 1'b0;
        dio_chain[g] <= 1'b0;
      end else begin
        clk_chain[g] <= clk_chain[g-1];
        dio_chain[g] <= dio_chain[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) clk_prev <= 1'b0;
    else        clk_prev <= clk_chain[STAGES-1];
  end

  assign rise  = clk_chain[STAGES-1] & ~clk_prev;
  assign dio_s = dio_chain[STAGES-1];
endmodule

// File: rtl/swd_hi_counter.sv
module swd_hi_counter #(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned RESET_MIN = 50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample,
  input  logic             dio_s,
  output logic [CNT_W-1:0] hi_cnt,
  output logic             reset_evt,
  output logic             reset_pulse,
  output logic [CNT_W-1:0] reset_len
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_MIN = CNT_W'(RESET_MIN);

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  assign reset_evt = sample && !dio_s && (hi_cnt >= CNT_MIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_cnt      <= '0;
      reset_pulse <= 1'b0;
      reset_len   <= '0;
    end else begin
      reset_pulse <= reset_evt;
      if (reset_evt) reset_len <= hi_cnt;
      if (sample) hi_cnt <= dio_s ? sat_inc(hi_cnt) : '0;
    end
  end
endmodule

// File: rtl/swd_switch_matcher.sv
module swd_switch_matcher #(
  parameter int unsigned     PAT_W   = 16,
  parameter logic [PAT_W-1:0] PATTERN = 16'hE79E
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample,
  input  logic dio_s,
  input  logic idle_req,
  input  logic clear,
  output logic match_evt,
  output logic switch_pulse
);
  logic [PAT_W-1:0] window;
  logic [PAT_W-1:0] window_nxt;

  function automatic logic [PAT_W-1:0] shift_lsb_first(input logic [PAT_W-1:0] w,
                                                       input logic b);
    return {b, w[PAT_W-1:1]};
  endfunction

  assign window_nxt = shift_lsb_first(window, dio_s);
  assign match_evt  = sample && idle_req && (window_nxt == PATTERN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      window       <= '0;
      switch_pulse <= 1'b0;
    end else begin
      switch_pulse <= match_evt;
      if (clear || match_evt) window <= '0;
      else if (sample)        window <= window_nxt;
    end
  end
endmodule

// File: rtl/swd_seq_detect.sv
module swd_seq_detect
  import swd_seq_pkg::*;
#(
  parameter int unsigned      CNT_W     = DEF_CNT_W,
  parameter int unsigned      RESET_MIN = DEF_RESET_MIN,
  parameter int unsigned      PAT_W     = DEF_PAT_W,
  parameter logic [PAT_W-1:0] PATTERN   = DEF_PATTERN,
  parameter int unsigned      SYNC      = DEF_SYNC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic             idle_req,
  input  logic             swclk_in,
  input  logic             swdio_in,
  output logic             line_reset_pulse,
  output logic             switch_pulse,
  output logic [CNT_W-1:0] reset_len
);
  logic             rise_evt;
  logic             dio_s;
  logic             sample;
  logic [CNT_W-1:0] hi_cnt;
  logic             reset_evt;
  logic             match_evt;

  swd_sync_edge #(.STAGES(SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .swclk_in(swclk_in), .swdio_in(swdio_in),
    .rise(rise_evt), .dio_s(dio_s)
  );

  assign sample = rise_evt & clk_en;

  swd_hi_counter #(.CNT_W(CNT_W), .RESET_MIN(RESET_MIN)) u_cnt (
    .clk(clk), .rst_n(rst_n), .sample(sample), .dio_s(dio_s),
    .hi_cnt(hi_cnt), .reset_evt(reset_evt),
    .reset_pulse(line_reset_pulse), .reset_len(reset_len)
  );

  swd_switch_matcher #(.PAT_W(PAT_W), .PATTERN(PATTERN)) u_match (
    .clk(clk), .rst_n(rst_n), .sample(sample), .dio_s(dio_s),
    .idle_req(idle_req), .clear(reset_evt),
    .match_evt(match_evt), .switch_pulse(switch_pulse)
  );
endmodule

// File: rtl/swd_seq_detect_chk.sv
module swd_seq_detect_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clk_en,
  input logic             idle_req,
  input logic             rise_evt,
  input logic             dio_s,
  input logic [CNT_W-1:0] hi_cnt,
  input logic             line_reset_pulse,
  input logic             switch_pulse
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  // R2: a line reset pulse follows a rising edge that sampled data low
  a_r2_reset_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    line_reset_pulse |-> $past(rise_evt && !dio_s));

  // R4: a full counter stays full while highs keep arriving
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_cnt == CMAX && rise_evt && clk_en && dio_s) |=> hi_cnt == CMAX);

  // R7: switch pulse only after a request-wait cycle
  a_r7_switch_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    switch_pulse |-> $past(idle_req));

  // R8: gated edges produce no pulse
  a_r8_gated_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> !line_reset_pulse && !switch_pulse);

  // R9: pulses last one cycle and never coincide
  a_r9_reset_single: assert property (@(posedge clk) disable iff (!rst_n)
    line_reset_pulse |=> !line_reset_pulse);
  a_r9_switch_single: assert property (@(posedge clk) disable iff (!rst_n)
    switch_pulse |=> !switch_pulse);
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(line_reset_pulse && switch_pulse));
endmodule

bind swd_seq_detect swd_seq_detect_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .idle_req(idle_req),
  .rise_evt(rise_evt), .dio_s(dio_s), .hi_cnt(hi_cnt),
  .line_reset_pulse(line_reset_pulse), .switch_pulse(switch_pulse)
);

// File: tb/test_swd_seq_detect.sv
module test_swd_seq_detect;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clk_en = 1'b1;
  logic       idle_req = 1'b1;
  logic       swclk_in = 1'b0;
  logic       swdio_in = 1'b0;
  logic       line_reset_pulse;
  logic       switch_pulse;
  logic [7:0] reset_len;

  int checks = 0;
  int errors = 0;
  int n_rst = 0, n_sw = 0, run_rst = 0, run_sw = 0, max_run = 0;
  bit done = 1'b0;

  localparam logic [15:0] SW_PAT = 16'hE79E;

  always #2 clk = ~clk;

  swd_seq_detect i_swd_seq_detect (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .idle_req(idle_req),
    .swclk_in(swclk_in), .swdio_in(swdio_in),
    .line_reset_pulse(line_reset_pulse), .switch_pulse(switch_pulse),
    .reset_len(reset_len)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (line_reset_pulse) n_rst++;
      if (switch_pulse) n_sw++;
      run_rst = line_reset_pulse ? run_rst + 1 : 0;
      run_sw  = switch_pulse ? run_sw + 1 : 0;
      if (run_rst > max_run) max_run = run_rst;
      if (run_sw > max_run) max_run = run_sw;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    swdio_in = b;
    swclk_in = 1'b0;
    repeat (4) @(negedge clk);
    swclk_in = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_ones(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b1);
  endtask

  task automatic send_pattern();
    for (int i = 0; i < 16; i++) send_bit(SW_PAT[i]);
  endtask

  task automatic clear_counts();
    n_rst = 0;
    n_sw = 0;
  endtask

  task automatic t_reset_state();
    check("R1 reset pulse", int'(line_reset_pulse), 0);
    check("R1 switch pulse", int'(switch_pulse), 0);
    check("R1 reset_len", int'(reset_len), 0);
  endtask

  task automatic t_exact_threshold();
    clear_counts();
    send_ones(50);
    send_bit(1'b0);
    check("R2 one line reset at 50", n_rst, 1);
    check("R2 reset_len 50", int'(reset_len), 50);
    send_bit(1'b0);
    check("R2 counter cleared after reset", n_rst, 1);
  endtask

  task automatic t_below_threshold();
    clear_counts();
    send_ones(49);
    send_bit(1'b0);
    check("R3 no reset at 49", n_rst, 0);
    check("R3 reset_len held", int'(reset_len), 50);
  endtask

  task automatic t_saturate();
    clear_counts();
    send_ones(300);
    send_bit(1'b0);
    check("R4 one reset after 300", n_rst, 1);
    check("R4 reset_len saturated", int'(reset_len), 255);
  endtask

  task automatic t_reset_busy();
    clear_counts();
    idle_req = 1'b0;
    send_ones(60);
    send_bit(1'b0);
    check("R5 reset with idle_req low", n_rst, 1);
    check("R5 reset_len 60", int'(reset_len), 60);
    idle_req = 1'b1;
  endtask

  task automatic t_switch_after_reset();
    send_ones(55);
    send_bit(1'b0);
    clear_counts();
    send_pattern();
    check("R6 switch after line reset", n_sw, 1);
    check("R6 no extra line reset", n_rst, 0);
  endtask

  task automatic t_switch_sliding();
    clear_counts();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b0); send_bit(1'b1);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    check("R6 no match on leading bits", n_sw, 0);
    send_pattern();
    check("R6 sliding window match", n_sw, 1);
  endtask

  task automatic t_switch_busy();
    clear_counts();
    idle_req = 1'b0;
    send_pattern();
    check("R7 no switch while busy", n_sw, 0);
    idle_req = 1'b1;
  endtask

  task automatic t_gated();
    clear_counts();
    send_ones(3);
    send_bit(1'b0);
    clk_en = 1'b0;
    send_ones(60);
    send_bit(1'b0);
    check("R8 gated run gives no reset", n_rst, 0);
    clk_en = 1'b1;
    send_bit(1'b0);
    check("R8 gated highs not counted", n_rst, 0);
    send_ones(52);
    clk_en = 1'b0;
    send_bit(1'b0);
    check("R8 gated low does not end run", n_rst, 0);
    clk_en = 1'b1;
    send_bit(1'b0);
    check("R8 run completes after enable", n_rst, 1);
    check("R8 reset_len 52", int'(reset_len), 52);
  endtask

  task automatic t_latency();
    send_ones(50);
    @(negedge clk);
    swdio_in = 1'b0;
    swclk_in = 1'b0;
    repeat (4) @(negedge clk);
    clear_counts();
    swclk_in = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 pulse within four cycles", n_rst, 1);
    check("R9 pulse width one cycle", max_run, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_exact_threshold();
    t_below_threshold();
    t_saturate();
    t_reset_busy();
    t_switch_after_reset();
    t_switch_sliding();
    t_switch_busy();
    t_gated();
    t_latency();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 150000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule